// File: doc/BRIEF.md
# AC-link Frame Serializer and Deserializer

This block is the controller end of an AC-link style serial audio link. It runs on the bit clock that the codec supplies and generates the frame marker SYNC itself. Each frame lasts 256 bit clocks: a 16-bit tag phase followed by twelve 20-bit slots. In every frame the block shifts one outgoing frame onto the serial output and assembles one incoming frame from the serial input. Only the tag and the first four slots carry content: command address, command data, left sample and right sample. Everything else goes out as zeros.

The parallel side gives an outgoing tag and four outgoing slot words. These are captured once at the start of each frame. Received frames come back as a tag, four slot words and a codec-ready flag. A start strobe marks the edge at which the outgoing words were taken. A done strobe marks the moment a full incoming frame has been assembled. Command sequencing and sample processing belong to the logic around this block.

Top module: `ac_link_ctrl`

## Requirements
- R1: The SYNC output rises once every 256 bit clocks. The frame_start_o pulse is high for exactly the cycle in which SYNC rises, and in no other cycle.
- R2: SYNC is active high and stays high for 16 consecutive bit clocks in each frame, covering the tag phase.
- R3: Serial output bits change on the rising edge and go most significant bit first, with a one-bit delay. Tag bit 15 is driven in the cycle after SYNC rises. The other 15 tag bits follow, then slots 1, 2, 3 and 4 at 20 bits each.
- R4: Slots 5 to 12 are always sent as zeros. Their tag flag bits (bits 10 down to 3) are also forced to zero. Tag bits 15 to 11 and 2 to 0 are sent as given.
- R5: Slot k of 1 to 4 has its valid flag in tag bit 15-k: slot 1 uses bit 14, slot 2 bit 13, slot 3 bit 12 and slot 4 bit 11. A slot whose flag is 0 is sent as all zeros.
- R6: tx_tag_i and tx_slots_i are sampled at the rising edge that raises SYNC. A change to them later in that frame has no effect on the bits being sent.
- R7: sdata_in is sampled on the falling bit clock edge with the same one-bit delay. The tag starts in the cycle after SYNC rises, and slots 1 to 4 follow. After the last bit of slot 12 (the cycle in which the next SYNC rises), frame_done_o pulses high for one cycle, one cycle after SYNC rises. rx_tag_o and rx_slots_o update together with it.
- R8: A received frame whose tag bit 15 is 0 is discarded: rx_tag_o and rx_slots_o keep their previous values. Bits received in slots 5 to 12 never reach the outputs.
- R9: codec_ready_o takes the value of bit 15 of the tag of each completed incoming frame, and is updated with frame_done_o.
- R10: A synchronous active-high reset holds SYNC, sdata_out, frame_start_o and frame_done_o low and clears rx_tag_o, rx_slots_o and codec_ready_o. SYNC rises at the first rising edge after reset is released.
- R11: No frame_done_o pulse appears until one whole incoming frame has been captured after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec |
| rst | input | 1 | Synchronous reset, active high |
| tx_tag_i | input | 16 | Outgoing tag word |
| tx_slots_i | input | 80 | Outgoing slots 1..4, slot 1 in bits 79:60 |
| sdata_in | input | 1 | Serial data from the codec |
| sync_o | output | 1 | Frame marker, high during the tag phase |
| sdata_out | output | 1 | Serial data to the codec |
| frame_start_o | output | 1 | Pulse: outgoing words were just sampled |
| frame_done_o | output | 1 | Pulse: an incoming frame has been assembled |
| rx_tag_o | output | 16 | Last accepted incoming tag |
| rx_slots_o | output | 80 | Last accepted incoming slots 1..4, slot 1 in bits 79:60 |
| codec_ready_o | output | 1 | Tag bit 15 of the last completed incoming frame |

## Verification
The bit counter, the outgoing shift register and the incoming shift register are the whole internal state. A slip in the counter shows on SYNC within the same frame, as a wrong period or a wrong high time. A wrong shift position or wrong slot gating shows on sdata_out within 16 to 96 cycles of the SYNC rise, because the bench compares every bit position. Misalignment in the receive path stays hidden until the next frame_done_o, at most 256 cycles later, when the exact contents of the tag and slots, the discard rule and the ready flag are all compared.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;

  // Total bit clocks in one frame.
  function automatic int unsigned frame_bits(int unsigned tag_w, int unsigned slot_w,
                                             int unsigned n_slots);
    return tag_w + n_slots * slot_w;
  endfunction

  // Bits that carry content: the tag plus the slots in use.
  function automatic int unsigned content_bits(int unsigned tag_w, int unsigned slot_w,
                                               int unsigned used);
    return tag_w + used * slot_w;
  endfunction

endpackage

// File: rtl/ac_link_timing.sv
module ac_link_timing #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned POS_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] next_pos_o,
  output logic             sync_o,
  output logic             frame_start_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  // The position counter names the bit slot currently on the outputs.
  always_comb begin
    if (pos_q == LAST_POS) next_pos_o = '0;
    else                   next_pos_o = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q         <= LAST_POS;
      sync_o        <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pos_q         <= next_pos_o;
      sync_o        <= (next_pos_o < POS_W'(TAG_W));
      frame_start_o <= (next_pos_o == '0);
    end
  end

  assign pos_o = pos_q;

  // Checker: length of the SYNC high run.
  logic [POS_W:0] high_run;
  always_ff @(posedge clk) begin
    if (rst)         high_run <= '0;
    else if (sync_o) high_run <= high_run + 1'b1;
    else             high_run <= '0;
  end

  assert_sync_width_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> (high_run == (POS_W+1)'(TAG_W)));

endmodule

// File: rtl/ac_link_tx.sv
module ac_link_tx #(
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned NUM_SLOTS  = 12,
  parameter int unsigned USED_SLOTS = 4,
  parameter int unsigned POS_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [POS_W-1:0]             pos_i,
  input  logic [POS_W-1:0]             next_pos_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [USED_SLOTS*SLOT_W-1:0] slots_i,
  output logic                         sdo_o
);

  localparam int unsigned CONTENT_W = TAG_W + USED_SLOTS * SLOT_W;

  logic [TAG_W-1:0]             tag_keep;
  logic [USED_SLOTS*SLOT_W-1:0] slot_gated;
  logic [CONTENT_W-1:0]         content;
  logic [CONTENT_W-1:0]         shreg;

  // Flags of slots that never carry content are cleared.
  always_comb begin
    tag_keep = '1;
    for (int k = USED_SLOTS + 1; k <= NUM_SLOTS; k++) tag_keep[TAG_W-1-k] = 1'b0;
  end

  // Slot k+1 is sent only when its tag flag is set.
  for (genvar k = 0; k < USED_SLOTS; k++) begin : g_gate
    assign slot_gated[(USED_SLOTS-k)*SLOT_W-1 -: SLOT_W] =
      tag_i[TAG_W-2-k] ? slots_i[(USED_SLOTS-k)*SLOT_W-1 -: SLOT_W] : '0;
  end

  assign content = {tag_i & tag_keep, slot_gated};

  // The shift register doubles as the frame-start latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      sdo_o <= 1'b0;
    end else if (next_pos_i == '0) begin
      shreg <= content;
      sdo_o <= 1'b0;
    end else begin
      shreg <= {shreg[CONTENT_W-2:0], 1'b0};
      sdo_o <= shreg[CONTENT_W-1];
    end
  end

  assert_tail_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ((pos_i == '0) || (pos_i > POS_W'(CONTENT_W))) |-> !sdo_o);

endmodule

// File: rtl/ac_link_rx.sv
module ac_link_rx #(
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned USED_SLOTS = 4,
  parameter int unsigned POS_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [POS_W-1:0]             pos_i,
  input  logic                         sdi,
  output logic [TAG_W-1:0]             tag_o,
  output logic [USED_SLOTS*SLOT_W-1:0] slots_o,
  output logic                         ready_o,
  output logic                         done_o
);

  localparam int unsigned CONTENT_W = TAG_W + USED_SLOTS * SLOT_W;

  logic                 samp;
  logic                 seen;
  logic [CONTENT_W-1:0] shreg;
  logic                 in_content;

  // Falling-edge capture, half a bit after the codec drives the line.
  always_ff @(negedge clk) begin
    if (rst) samp <= 1'b0;
    else     samp <= sdi;
  end

  assign in_content = (pos_i != '0) && (pos_i <= POS_W'(CONTENT_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      seen    <= 1'b0;
      done_o  <= 1'b0;
      tag_o   <= '0;
      slots_o <= '0;
      ready_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (in_content) shreg <= {shreg[CONTENT_W-2:0], samp};
      if (pos_i == POS_W'(1)) seen <= 1'b1;
      if ((pos_i == '0) && seen) begin
        done_o  <= 1'b1;
        ready_o <= shreg[CONTENT_W-1];
        if (shreg[CONTENT_W-1]) begin
          tag_o   <= shreg[CONTENT_W-1 -: TAG_W];
          slots_o <= shreg[USED_SLOTS*SLOT_W-1:0];
        end
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_discard_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !ready_o) |-> ($stable(tag_o) && $stable(slots_o)));

endmodule

// File: rtl/ac_link_ctrl.sv
module ac_link_ctrl #(
  parameter int unsigned TAG_W      = 16,
  parameter int unsigned SLOT_W     = 20,
  parameter int unsigned NUM_SLOTS  = 12,
  parameter int unsigned USED_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [TAG_W-1:0]             tx_tag_i,
  input  logic [USED_SLOTS*SLOT_W-1:0] tx_slots_i,
  input  logic                         sdata_in,
  output logic                         sync_o,
  output logic                         sdata_out,
  output logic                         frame_start_o,
  output logic                         frame_done_o,
  output logic [TAG_W-1:0]             rx_tag_o,
  output logic [USED_SLOTS*SLOT_W-1:0] rx_slots_o,
  output logic                         codec_ready_o
);

  import ac_link_pkg::*;

  localparam int unsigned FRAME_LEN = frame_bits(TAG_W, SLOT_W, NUM_SLOTS);
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;

  ac_link_timing #(.TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_timing (
    .clk(clk), .rst(rst), .pos_o(pos), .next_pos_o(next_pos),
    .sync_o(sync_o), .frame_start_o(frame_start_o)
  );

  ac_link_tx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
               .USED_SLOTS(USED_SLOTS), .POS_W(POS_W)) u_tx (
    .clk(clk), .rst(rst), .pos_i(pos), .next_pos_i(next_pos),
    .tag_i(tx_tag_i), .slots_i(tx_slots_i), .sdo_o(sdata_out)
  );

  ac_link_rx #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .USED_SLOTS(USED_SLOTS),
               .POS_W(POS_W)) u_rx (
    .clk(clk), .rst(rst), .pos_i(pos), .sdi(sdata_in),
    .tag_o(rx_tag_o), .slots_o(rx_slots_o), .ready_o(codec_ready_o),
    .done_o(frame_done_o)
  );

  // Checker: spacing between frame starts.
  logic [POS_W:0] gap;
  logic           fs_seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      fs_seen <= 1'b0;
    end else if (frame_start_o) begin
      gap     <= '0;
      fs_seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  assert_frame_period_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_start_o && fs_seen) |-> (gap == (POS_W+1)'(FRAME_LEN - 1)));

  assert_start_on_sync_R1: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> $rose(sync_o));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (!sync_o && !sdata_out && !frame_done_o && !frame_start_o));

endmodule

// File: tb/sim_ac_link_ctrl.sv
module sim_ac_link_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] tx_tag;
  logic [79:0] tx_slots;
  logic        sdi;
  logic        sync_o, sdata_out, frame_start_o, frame_done_o, codec_ready_o;
  logic [15:0] rx_tag_o;
  logic [79:0] rx_slots_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [15:0] cur_tag, nxt_tag, exp_rx_tag;
  logic [79:0] cur_slots, nxt_slots, exp_rx_slots;
  logic        exp_ready;
  bit          have_prev;

  always #5 clk = ~clk;

  ac_link_ctrl u0 (
    .clk(clk), .rst(rst), .tx_tag_i(tx_tag), .tx_slots_i(tx_slots), .sdata_in(sdi),
    .sync_o(sync_o), .sdata_out(sdata_out), .frame_start_o(frame_start_o),
    .frame_done_o(frame_done_o), .rx_tag_o(rx_tag_o), .rx_slots_o(rx_slots_o),
    .codec_ready_o(codec_ready_o)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Expected serial content: tag with slot 5..12 flags cleared, gated slots.
  function automatic logic [95:0] frame_content(logic [15:0] t, logic [79:0] s);
    logic [79:0] g = s;
    for (int k = 1; k <= 4; k++) if (!t[15-k]) g[99-20*k -: 20] = '0;
    return {t & 16'hF807, g};
  endfunction

  // One full frame starting just after the edge that raised SYNC.
  task automatic run_frame(input logic [15:0] c_tag, input logic [79:0] c_slots,
                           input bit scramble);
    logic [95:0] content = frame_content(cur_tag, cur_slots);
    logic [95:0] codec   = {c_tag, c_slots};
    for (int p = 0; p < 256; p++) begin
      check(sync_o === (p < 16), (p < 16) ? "R2 sync high" : "R1 sync low",
            96'(sync_o), 96'(p < 16));
      check(frame_start_o === (p == 0), "R1 frame_start", 96'(frame_start_o), 96'(p == 0));
      if (p >= 1 && p <= 96)
        check(sdata_out === content[96-p],
              (p <= 16) ? "R3 tag bit" : (cur_tag[15-((p-17)/20+1)] ? "R3 slot bit" : "R5 gated slot"),
              96'(sdata_out), 96'(content[96-p]));
      else
        check(sdata_out === 1'b0, "R4 idle zero", 96'(sdata_out), 96'(0));
      check(frame_done_o === (p == 1 && have_prev), "R7 R11 frame_done",
            96'(frame_done_o), 96'(p == 1 && have_prev));
      if (p == 1 && have_prev) begin
        check(codec_ready_o === exp_ready, "R9 codec_ready", 96'(codec_ready_o), 96'(exp_ready));
        check(rx_tag_o === exp_rx_tag, "R7 R8 rx_tag", 96'(rx_tag_o), 96'(exp_rx_tag));
        check(rx_slots_o === exp_rx_slots, "R7 R8 rx_slots", 96'(rx_slots_o), 96'(exp_rx_slots));
      end
      sdi = (p >= 1 && p <= 96) ? codec[96-p] : 1'b1;
      if (scramble && p == 40) begin
        tx_tag   = ~cur_tag;
        tx_slots = ~cur_slots;
      end
      if (p == 255) begin
        tx_tag   = nxt_tag;
        tx_slots = nxt_slots;
      end
      @(posedge clk); #1;
    end
    have_prev = 1'b1;
    exp_ready = c_tag[15];
    if (c_tag[15]) begin
      exp_rx_tag   = c_tag;
      exp_rx_slots = c_slots;
    end
    cur_tag   = nxt_tag;
    cur_slots = nxt_slots;
  endtask

  task automatic test_reset();
    rst = 1'b1; sdi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(sync_o === 1'b0, "R10 sync in reset", 96'(sync_o), 96'(0));
    check(sdata_out === 1'b0, "R10 sdata_out in reset", 96'(sdata_out), 96'(0));
    check(frame_done_o === 1'b0, "R10 frame_done in reset", 96'(frame_done_o), 96'(0));
    check(codec_ready_o === 1'b0, "R10 codec_ready in reset", 96'(codec_ready_o), 96'(0));
    check(rx_tag_o === 16'h0, "R10 rx_tag in reset", 96'(rx_tag_o), 96'(0));
    rst = 1'b0;
    @(posedge clk); #1;
    check(sync_o === 1'b1, "R10 first sync", 96'(sync_o), 96'(1));
  endtask

  // Slots 1,2 flagged, 3,4 not: gated to zero. Codec answers ready.
  task automatic test_basic_frame();
    nxt_tag = 16'hF800; nxt_slots = {20'h13579, 20'h2468A, 20'hCAFE1, 20'h0F0F0};
    run_frame(16'hF800, {20'hA1B2C, 20'h3D4E5, 20'h6F708, 20'h192A3}, 1'b0);
  endtask

  // Inputs disturbed mid-frame (R6); codec frame not valid (R8).
  task automatic test_latch_and_discard();
    nxt_tag = 16'h9FFF; nxt_slots = {20'hFFFFF, 20'hFFFFF, 20'h80001, 20'h7FFFE};
    run_frame(16'h7800, {20'h11111, 20'h22222, 20'h33333, 20'h44444}, 1'b1);
  endtask

  // Slot 5..12 flags cleared, low tag bits kept (R4, R5).
  task automatic test_tag_masking();
    nxt_tag = 16'h0000; nxt_slots = '1;
    run_frame(16'h9000, {20'h55555, 20'hAAAAA, 20'h0000F, 20'hF0000}, 1'b0);
  endtask

  // No slot flagged: only zeros go out.
  task automatic test_all_invalid();
    nxt_tag = 16'hE000; nxt_slots = {20'h00001, 20'h80000, 20'h12345, 20'h54321};
    run_frame(16'h8000, {20'hFEDCB, 20'h01234, 20'h00000, 20'hFFFFF}, 1'b0);
    run_frame(16'hE000, {20'h0ACE0, 20'h0BDF0, 20'h0, 20'h0}, 1'b0);
  endtask

  // Reset in mid-operation clears everything and restarts framing.
  task automatic test_reset_again();
    repeat (30) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check(sync_o === 1'b0, "R10 sync after reset", 96'(sync_o), 96'(0));
    check(sdata_out === 1'b0, "R10 sdata_out after reset", 96'(sdata_out), 96'(0));
    check(rx_tag_o === 16'h0, "R10 rx_tag cleared", 96'(rx_tag_o), 96'(0));
    check(rx_slots_o === 80'h0, "R10 rx_slots cleared", 96'(rx_slots_o), 96'(0));
    check(codec_ready_o === 1'b0, "R10 codec_ready cleared", 96'(codec_ready_o), 96'(0));
    rst = 1'b0;
    @(posedge clk); #1;
    check(sync_o === 1'b1 && frame_start_o === 1'b1, "R10 restart sync",
          96'({sync_o, frame_start_o}), 96'(3));
    @(posedge clk); #1;
    check(frame_done_o === 1'b0, "R11 no done after restart", 96'(frame_done_o), 96'(0));
  endtask

  initial begin
    rst = 1'b1; sdi = 1'b0; have_prev = 1'b0;
    exp_rx_tag = '0; exp_rx_slots = '0; exp_ready = 1'b0;
    cur_tag = 16'hE000; cur_slots = {20'hABCDE, 20'h12345, 20'hFFFFF, 20'h55555};
    tx_tag = cur_tag; tx_slots = cur_slots;
    nxt_tag = cur_tag; nxt_slots = cur_slots;
    test_reset();
    test_basic_frame();
    test_latch_and_discard();
    test_tag_masking();
    test_all_invalid();
    test_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R1: watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule